// File: doc/BRIEF.md
# Output Impedance Calibration Controller

This controller keeps the drive-strength code of an output driver tracking its target impedance. Once every evaluation period it reads a one-bit comparator flag that says whether the driver should get stronger or weaker. It then moves a private working code by exactly one step in that direction. The working code stops at either end of its range and never wraps.

The driver only sees a code that was copied across while the output was in high impedance. A change therefore never lands in the middle of a driven bit. If an evaluation finishes while the output is driving, the new value waits in the working register. It is copied at the next high-impedance cycle, or on every cycle of a high-impedance stretch.

A warm-up counter runs from reset. The calibrated flag rises on the first entry into high impedance after the warm-up window has fully elapsed. It then stays high until reset.

Top module: `imp_cal_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it falls, `drv_code` equals the midpoint 16 and `calibrated` is 0.
- R2: The working code changes only on the clock edge that ends each window of 64 cycles. The first such edge is the 64th edge after reset is released. The code moves by exactly one step on each such edge.
- R3: `cmp_up` = 1 sampled at an evaluation edge raises the working code by one. `cmp_up` = 0 lowers it by one.
- R4: The working code saturates. It stays at 31 when raised and at 0 when lowered.
- R5: `drv_code` changes only on an edge where `out_hiz` was 1. While `out_hiz` is 0, `drv_code` holds even when evaluations move the working code.
- R6: A working code left pending while the output drove appears on `drv_code` one edge after `out_hiz` rises.
- R7: `calibrated` rises only on a 0-to-1 transition of `out_hiz` seen after 2048 cycles have passed since reset. It stays 0 if `out_hiz` never transitions after that point, even while `out_hiz` is held high. Once set, it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_up | input | 1 | Comparator result: 1 means step up, 0 means step down |
| out_hiz | input | 1 | 1 while the driven output is in high impedance |
| drv_code | output | 5 | Impedance code applied to the driver |
| calibrated | output | 1 | Set once the warm-up and a high-impedance entry have both occurred |

## Verification
The bench holds the output in drive while evaluations move the working code. It checks that `drv_code` stays frozen, which a design copying the code unconditionally would fail. It then raises `out_hiz` for a single cycle, which catches a design that drops the pending value or delays its transfer. It samples half-way through an evaluation window to catch a design that steps more often than once per window. It drives the code hard against both ends, where a wrapping counter would jump from 31 to 0. It also holds `out_hiz` high across the end of warm-up, so a design that treats a level as an entry would set `calibrated` too early.

// File: rtl/imp_cal_ctrl.sv
module imp_cal_ctrl #(
  parameter int CODE_W        = 5,
  parameter int EVAL_CYCLES   = 64,
  parameter int WARMUP_CYCLES = 2048
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_up,
  input  logic              out_hiz,
  output logic [CODE_W-1:0] drv_code,
  output logic              calibrated
);
  localparam int EW = $clog2(EVAL_CYCLES);
  localparam int WW = $clog2(WARMUP_CYCLES + 1);
  localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] CODE_TOP = '1;
  localparam logic [EW-1:0]     EVAL_LAST = EW'(EVAL_CYCLES - 1);
  localparam logic [WW-1:0]     WARM_END  = WW'(WARMUP_CYCLES);

  logic [EW-1:0]     eval_cnt;
  logic [WW-1:0]     warm_cnt;
  logic [CODE_W-1:0] work_code;
  logic              hiz_q;

  wire eval_tick = (eval_cnt == EVAL_LAST);
  wire warm_done = (warm_cnt == WARM_END);
  wire hiz_entry = out_hiz & ~hiz_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      eval_cnt   <= '0;
      warm_cnt   <= '0;
      work_code  <= CODE_MID;
      drv_code   <= CODE_MID;
      hiz_q      <= 1'b0;
      calibrated <= 1'b0;
    end else begin
      hiz_q    <= out_hiz;
      eval_cnt <= eval_tick ? '0 : eval_cnt + 1'b1;
      if (!warm_done) warm_cnt <= warm_cnt + 1'b1;
      if (eval_tick) begin
        if (cmp_up && work_code != CODE_TOP)  work_code <= work_code + 1'b1;
        else if (!cmp_up && work_code != '0)  work_code <= work_code - 1'b1;
      end
      if (out_hiz) drv_code <= work_code;
      if (hiz_entry && warm_done) calibrated <= 1'b1;
    end
  end

  assert_work_step_R2: assert property (@(posedge clk) disable iff (rst)
    (work_code != $past(work_code)) |-> ($past(eval_tick) &&
      (work_code == $past(work_code) + 1'b1 || work_code == $past(work_code) - 1'b1)));

  assert_saturate_top_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(work_code) == CODE_TOP && $past(cmp_up)) |-> (work_code == CODE_TOP));

  assert_saturate_bottom_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(work_code) == '0 && !$past(cmp_up)) |-> (work_code == '0));

  assert_drive_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    (drv_code != $past(drv_code)) |-> $past(out_hiz));

  assert_cal_entry_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(calibrated) |-> ($past(warm_done) && $past(out_hiz) && !$past(hiz_q)));

  assert_cal_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    $past(calibrated) |-> calibrated);
endmodule

// File: tb/sim_imp_cal_ctrl.sv
module sim_imp_cal_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp_up = 1'b0;
  logic out_hiz = 1'b0;
  logic [4:0] drv_code;
  logic calibrated;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  imp_cal_ctrl u0 (
    .clk(clk), .rst(rst), .cmp_up(cmp_up), .out_hiz(out_hiz),
    .drv_code(drv_code), .calibrated(calibrated)
  );

  // {cmp_up, out_hiz, expected calibrated, expected drv_code}
  localparam logic [7:0] VEC [6] = '{
    {1'b1, 1'b1, 1'b0, 5'd17},
    {1'b1, 1'b1, 1'b0, 5'd18},
    {1'b0, 1'b1, 1'b0, 5'd17},
    {1'b1, 1'b0, 1'b0, 5'd17},
    {1'b1, 1'b0, 1'b0, 5'd17},
    {1'b0, 1'b1, 1'b0, 5'd18}
  };

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    edges(3);
    check("R1 code in reset", drv_code, 16);
    check("R1 flag in reset", calibrated, 0);
    rst = 1'b0;
    edges(1);
    check("R1 code after release", drv_code, 16);
    check("R1 flag after release", calibrated, 0);

    for (int i = 0; i < 6; i++) begin
      cmp_up  = VEC[i][7];
      out_hiz = VEC[i][6];
      edges(64);
      check($sformatf("R2/R3/R5 vector %0d code", i), drv_code, VEC[i][4:0]);
      check($sformatf("R7 vector %0d flag", i), calibrated, VEC[i][5]);
    end

    cmp_up = 1'b1;
    edges(32);
    check("R2 no step mid-window", drv_code, 18);
    edges(32);
    check("R2 one step at window end", drv_code, 19);

    out_hiz = 1'b0;
    edges(64);
    check("R5 code frozen while driving", drv_code, 19);
    out_hiz = 1'b1;
    edges(1);
    check("R6 pending code transferred", drv_code, 20);

    edges(64 * 40);
    check("R4 saturate at 31", drv_code, 31);
    check("R7 no entry after warm-up, flag low", calibrated, 0);
    cmp_up = 1'b0;
    edges(64 * 40);
    check("R4 saturate at 0", drv_code, 0);

    out_hiz = 1'b0;
    edges(2);
    check("R7 flag low while driving", calibrated, 0);
    out_hiz = 1'b1;
    edges(1);
    check("R7 flag on hiz entry", calibrated, 1);
    out_hiz = 1'b0;
    edges(3);
    check("R7 flag sticky", calibrated, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule